// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Upper-Half Write Lock

This block is a synthesizable model of a 256-byte serial memory that answers as a slave on a two-wire bus. SCL and SDA are oversampled on a fast system clock. SDA is observed as an input, and the block pulls the line low through a separate open-drain enable. It never drives the line high. The block recognises bus Start and Stop conditions and compares the received device address against a fixed prefix and three strap inputs, so that eight such devices can share one bus.

A write transaction carries a word-address byte followed by data bytes. The data bytes are gathered in a small page buffer that wraps inside an aligned 8-byte page. They reach the array only when the master sends Stop. A lock input protects the upper half of the array. A supply-low input blocks every array update.

Reads return bytes MSB first from an internal pointer that wraps over the whole array. A read can start from the address set by a preceding word-address byte and a repeated Start (random read). It can also start from wherever the last access left the pointer (current-address read).

Top module: `eep2w_slave`

## Requirements
- R1: After reset the block does not pull SDA, every array location reads 00h, and the internal pointer is 00h.
- R2: The device byte (MSB first) matches when bits 7..4 are 1010b and bits 3..1 equal `sel_strap_i[2:0]`. Bit 0 is 1 for read and 0 for write. On a match the block pulls SDA low for the whole ninth SCL clock. On a mismatch it does not pull SDA at all.
- R3: The pull-down enable only switches on while SCL is low. During any SCL high phase the level the block puts on SDA stays stable.
- R4: A Start condition (SDA falling while SCL is high), including a repeated Start, releases SDA and restarts device-address matching. A Stop condition (SDA rising while SCL is high) returns the block to idle.
- R5: In a write, the word-address byte loads the pointer, and each data byte is acknowledged. A data byte is placed at the pointer, and then only the pointer's low three bits increment, wrapping inside the aligned 8-byte page.
- R6: Buffered write data reaches the array only at Stop. A Start that arrives before Stop discards the buffered bytes.
- R7: While `wr_lock_i` is high at Stop, locations 80h–FFh are not updated and locations 00h–7Fh are. Every byte of a locked write is still acknowledged.
- R8: While `wr_lock_i` is low, locations in both halves of the array are updated at Stop.
- R9: While `supply_low_i` is high at Stop, no location is updated.
- R10: A read places each data bit on SDA after an SCL fall, MSB first. After each byte the pointer increments, wrapping from FFh to 00h.
- R11: When the master does not acknowledge a read byte, the block stops transmitting and leaves SDA released until the next Start.
- R12: A read without a preceding word-address byte starts at the pointer left by the previous access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| sel_strap_i | input | 3 | Strap bits compared with device-address bits 3..1 |
| wr_lock_i | input | 1 | 1 protects locations 80h–FFh from writes |
| supply_low_i | input | 1 | 1 inhibits every array update |

## Verification
Faults in this block show up at the ports at different times.

- **Acknowledge logic:** a wrong address-match or acknowledge decision shows within the same byte, as a missing or spurious low level during the ninth SCL clock.
- **Pointer or page-buffer state:** a corrupt pointer or buffer stays hidden until a later read transaction returns a wrong byte. The bench therefore reads back every write, reads across page and array boundaries, and follows each write with a current-address read.
- **Commit gating:** a fault in the lock or supply-low gating only changes which bytes later reads return. Each inhibited write is therefore paired with a write to an unprotected location, and both are read back.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;

  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STRAP_W = 3;
  localparam logic [3:0]  DEV_PREFIX = 4'b1010;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } ctl_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } rx_kind_e;

  // device byte selects this slave
  function automatic logic addr_matches(byte_t b, logic [STRAP_W-1:0] strap);
    return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
  endfunction

  // advance only the in-page bits of an address
  function automatic addr_t page_step(addr_t a, int unsigned pw);
    addr_t m;
    m = addr_t'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + addr_t'(1)) & m);
  endfunction

  // array update inhibited for this page
  function automatic logic write_blocked(logic upper, logic lock, logic low);
    return low | (lock & upper);
  endfunction

endpackage

// File: rtl/eep2w_sync.sv
module eep2w_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eep2w_array.sv
module eep2w_array
  import eep2w_pkg::*;
#(
  parameter int unsigned PAGE_W = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  addr_t                              rd_addr,
  output byte_t                              rd_data,
  input  logic                               wr_en,
  input  logic [ADDR_W-PAGE_W-1:0]           wr_page,
  input  logic [(1<<PAGE_W)-1:0]             wr_mask,
  input  logic [(BYTE_W<<PAGE_W)-1:0]        wr_data
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned PAGE   = 1 << PAGE_W;
  localparam int unsigned PIDX_W = ADDR_W - PAGE_W;

  byte_t mem [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    localparam int unsigned SLOT = r % PAGE;
    localparam int unsigned PIDX = r / PAGE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[r] <= '0;
      else if (wr_en && (wr_page == PIDX_W'(PIDX)) && wr_mask[SLOT])
        mem[r] <= wr_data[SLOT*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eep2w_ctrl.sv
module eep2w_ctrl
  import eep2w_pkg::*;
#(
  parameter int unsigned PAGE_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_rise,
  input  logic                          scl_fall,
  input  logic                          start_evt,
  input  logic                          stop_evt,
  input  logic                          sda_s,
  input  logic [STRAP_W-1:0]            strap,
  input  logic                          wr_lock,
  input  logic                          supply_low,
  input  byte_t                         rd_data,
  output addr_t                         rd_addr,
  output logic                          sda_pull,
  output logic                          commit_en,
  output logic [ADDR_W-PAGE_W-1:0]      commit_page,
  output logic [(1<<PAGE_W)-1:0]        commit_mask,
  output logic [(BYTE_W<<PAGE_W)-1:0]   commit_data
);

  localparam int unsigned PAGE   = 1 << PAGE_W;
  localparam int unsigned PIDX_W = ADDR_W - PAGE_W;

  ctl_state_e        st;
  rx_kind_e          kind;
  logic [3:0]        cnt;
  byte_t             sh;
  logic              full, rw, ack_go;
  addr_t             ptr;
  logic [PIDX_W-1:0] pg;
  logic [PAGE-1:0]   vmask;
  byte_t             pbuf [PAGE];
  byte_t             rx_byte;

  assign rx_byte = {sh[BYTE_W-2:0], sda_s};

  assign commit_en   = stop_evt && (|vmask) &&
                       !write_blocked(pg[PIDX_W-1], wr_lock, supply_low);
  assign commit_page = pg;
  assign commit_mask = vmask;
  assign rd_addr     = ptr;

  for (genvar i = 0; i < PAGE; i++) begin : g_pack
    assign commit_data[i*BYTE_W +: BYTE_W] = pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= RX_DEV;
      cnt      <= '0;
      sh       <= '0;
      full     <= 1'b0;
      rw       <= 1'b0;
      ack_go   <= 1'b0;
      ptr      <= '0;
      pg       <= '0;
      vmask    <= '0;
      sda_pull <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (start_evt) begin
      st       <= ST_RX;
      kind     <= RX_DEV;
      cnt      <= '0;
      full     <= 1'b0;
      vmask    <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      st       <= ST_IDLE;
      full     <= 1'b0;
      vmask    <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && !full) begin
            sh  <= rx_byte;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              full <= 1'b1;
              case (kind)
                RX_DEV: begin
                  ack_go <= addr_matches(rx_byte, strap);
                  rw     <= rx_byte[0];
                end
                RX_WADDR: begin
                  ack_go <= 1'b1;
                  ptr    <= rx_byte;
                  pg     <= rx_byte[ADDR_W-1:PAGE_W];
                  vmask  <= '0;
                end
                default: begin
                  ack_go                    <= 1'b1;
                  pbuf[ptr[PAGE_W-1:0]]     <= rx_byte;
                  vmask[ptr[PAGE_W-1:0]]    <= 1'b1;
                  ptr                       <= page_step(ptr, PAGE_W);
                end
              endcase
            end
          end else if (scl_fall && full) begin
            full     <= 1'b0;
            sda_pull <= ack_go;
            st       <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            if (!ack_go) begin
              st <= ST_IDLE;
            end else if (kind == RX_DEV && rw) begin
              st       <= ST_TX;
              sh       <= {rd_data[BYTE_W-2:0], 1'b0};
              sda_pull <= ~rd_data[BYTE_W-1];
              ptr      <= ptr + addr_t'(1);
            end else begin
              st   <= ST_RX;
              kind <= (kind == RX_DEV) ? RX_WADDR : RX_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull <= 1'b0;
              st       <= ST_MACK;
            end else begin
              sda_pull <= ~sh[BYTE_W-1];
              sh       <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ack_go <= ~sda_s;
            if (sda_s) st <= ST_IDLE;
          end else if (scl_fall && ack_go) begin
            st       <= ST_TX;
            cnt      <= '0;
            sh       <= {rd_data[BYTE_W-2:0], 1'b0};
            sda_pull <= ~rd_data[BYTE_W-1];
            ptr      <= ptr + addr_t'(1);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
  import eep2w_pkg::*;
#(
  parameter int unsigned PAGE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] sel_strap_i,
  input  logic               wr_lock_i,
  input  logic               supply_low_i
);

  localparam int unsigned PIDX_W = ADDR_W - PAGE_W;
  localparam int unsigned PAGE   = 1 << PAGE_W;

  // named internal events, also observed by the checker
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic commit_en, commit_hi;
  logic [PIDX_W-1:0]      commit_page;
  logic [PAGE-1:0]        commit_mask;
  logic [BYTE_W*PAGE-1:0] commit_data;
  addr_t rd_addr;
  byte_t rd_data;

  eep2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep2w_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .strap(sel_strap_i), .wr_lock(wr_lock_i), .supply_low(supply_low_i),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_pull(sda_pull_o),
    .commit_en(commit_en), .commit_page(commit_page),
    .commit_mask(commit_mask), .commit_data(commit_data)
  );

  eep2w_array #(.PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(commit_en), .wr_page(commit_page), .wr_mask(commit_mask),
    .wr_data(commit_data)
  );

  assign commit_hi = commit_page[PIDX_W-1];

endmodule

// File: rtl/eep2w_chk.sv
module eep2w_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic start_evt,
  input logic stop_evt,
  input logic commit_en,
  input logic commit_hi,
  input logic wr_lock,
  input logic supply_low
);

  assert_pull_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  assert_start_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  assert_commit_only_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> stop_evt);

  assert_lock_upper_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && wr_lock) |-> !commit_hi);

  assert_supply_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> !supply_low);

endmodule

bind eep2w_slave eep2w_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .start_evt(start_evt), .stop_evt(stop_evt), .commit_en(commit_en),
  .commit_hi(commit_hi), .wr_lock(wr_lock_i), .supply_low(supply_low_i)
);

// File: tb/test_eep2w_slave.sv
module test_eep2w_slave;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic lock = 1'b0, low = 1'b0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  eep2w_slave i_eep2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .sel_strap_i(strap), .wr_lock_i(lock),
    .supply_low_i(low)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] bptr = 8'h00;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (10) @(negedge clk); endtask
  task automatic lo(); scl_m = 1'b0; repeat (2) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); lo();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); lo();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (5) @(negedge clk);
    acked = !sda_line;
    repeat (5) @(negedge clk);
    lo();
  endtask

  // R3 and R10: bit sampled MSB first, level stable through SCL high
  task automatic recv_byte(input bit mack);
    logic [7:0] v;
    logic first;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1;
      repeat (3) @(negedge clk);
      first = sda_line;
      repeat (5) @(negedge clk);
      v[i] = sda_line;
      check(first == sda_line, "R3", int'(sda_line), int'(first));
      repeat (2) @(negedge clk);
      lo();
    end
    obs_q.push_back(v);
    sda_m = mack ? 1'b0 : 1'b1; hp(); scl_m = 1'b1; hp(); lo(); sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [2:0] sel, input logic [7:0] a, input int n,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input bit exp_dev_ack);
    bit ack;
    logic [7:0] d [3];
    logic [7:0] idx;
    logic [7:0] pv [8];
    bit         pm [8];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int k = 0; k < 8; k++) pm[k] = 0;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    check(ack == exp_dev_ack, "R2", int'(ack), int'(exp_dev_ack));
    if (!ack) begin bus_stop(); return; end
    send_byte(a, ack);
    check(ack, "R5", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack);
      check(ack, (lock && a[7]) ? "R7" : "R5", int'(ack), 1);
      idx = {a[7:3], 3'(a[2:0] + k)};
      pv[idx[2:0]] = d[k]; pm[idx[2:0]] = 1;
    end
    bptr = {a[7:3], 3'(a[2:0] + n)};
    bus_stop();
    if (!low && !(lock && a[7]))
      for (int k = 0; k < 8; k++) if (pm[k]) ref_mem[{a[7:3], 3'(k)}] = pv[k];
  endtask

  task automatic read_txn(input bit random, input logic [7:0] a, input int n, input string tag);
    bit ack;
    bus_start();
    if (random) begin
      send_byte({4'b1010, strap, 1'b0}, ack);
      check(ack, "R12", int'(ack), 1);
      send_byte(a, ack);
      check(ack, "R5", int'(ack), 1);
      bptr = a;
      bus_start();
      send_byte({4'b1010, strap, 1'b1}, ack);
      check(ack, "R4", int'(ack), 1);
    end else begin
      send_byte({4'b1010, strap, 1'b1}, ack);
      check(ack, "R12", int'(ack), 1);
    end
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[bptr]);
      tag_q.push_back(tag);
      bptr = bptr + 8'd1;
      recv_byte(i < n - 1);
    end
    // R11: released after the master's NACK
    sda_m = 1'b1; hp(); scl_m = 1'b1; repeat (5) @(negedge clk);
    check(sda_line == 1'b1, "R11", int'(sda_line), 1);
    repeat (5) @(negedge clk); lo();
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    logic [7:0] v, e;
    string t;
    forever begin
      wait (obs_q.size() != 0);
      v = obs_q.pop_front();
      if (exp_q.size() == 0) check(0, "scoreboard", int'(v), 0);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(v == e, t, int'(v), int'(e));
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R1", int'(sda_pull), 0);
    read_txn(0, 8'h00, 1, "R1");

    write_txn(3'b101, 8'h10, 1, 8'hA5, 8'h00, 8'h00, 1);
    read_txn(1, 8'h10, 2, "R6");

    write_txn(3'b011, 8'h12, 1, 8'h44, 8'h00, 8'h00, 0);
    bus_start();
    send_byte(8'hBA, ack);
    check(!ack, "R2", int'(ack), 0);
    bus_stop();
    read_txn(1, 8'h12, 1, "R2");

    write_txn(3'b101, 8'h86, 3, 8'h01, 8'h02, 8'h03, 1);
    read_txn(1, 8'h80, 8, "R8");
    read_txn(0, 8'h00, 1, "R12");

    lock = 1'b1;
    write_txn(3'b101, 8'h90, 1, 8'h55, 8'h00, 8'h00, 1);
    write_txn(3'b101, 8'h20, 1, 8'h66, 8'h00, 8'h00, 1);
    lock = 1'b0;
    read_txn(1, 8'h90, 1, "R7");
    read_txn(1, 8'h20, 1, "R7");

    low = 1'b1;
    write_txn(3'b101, 8'h30, 1, 8'h77, 8'h00, 8'h00, 1);
    low = 1'b0;
    read_txn(1, 8'h30, 1, "R9");

    // R6: repeated Start before Stop drops the buffered byte
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_byte(8'h11, ack);
    bus_start();
    bus_stop();
    read_txn(1, 8'h40, 1, "R6");

    write_txn(3'b101, 8'hFF, 1, 8'hEE, 8'h00, 8'h00, 1);
    write_txn(3'b101, 8'h00, 2, 8'h3C, 8'h9A, 8'h00, 1);
    read_txn(1, 8'hFF, 2, "R10");
    read_txn(0, 8'h00, 1, "R12");

    wait (obs_q.size() == 0);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule